// File: doc/BRIEF.md
# SDRAM Start-up Command Sequencer

After reset this block drives the command, address and control pins of a synchronous DRAM through the start-up sequence the memory needs before it accepts normal traffic. Clock enable and the byte masks stay high the whole time. The block holds a no-operation command while the supply and clock settle. It then closes every bank with one precharge-all, issues a programmable number of auto-refresh commands, and writes the mode register. The mode word is assembled from parameters: burst length code, wrap type, CAS latency and the single-write option.

Every delay is a parameter counted in clock cycles. When the last wait has elapsed, `init_done` rises and stays high until the next reset. From then on the pins hold no-operation, so a multiplexer outside the block can hand the bus to the normal controller. Reset is synchronous and active high. Asserting it at any point restarts the sequence from the beginning.

Top module: `sdram_init_seq`

## Requirements
- R1: Counting clock edges after reset is released from 1, the command is no-operation after edges 1 to WAIT_CYCLES-1. The command after edge WAIT_CYCLES is the precharge-all. A command is the tuple (cs_n, ras_n, cas_n, we_n), and no-operation is 0111.
- R2: `sd_cke` is 1 and every bit of `sd_dqm` is 1 on every cycle, including during reset.
- R3: Precharge-all is encoded 0010, with `sd_addr` bit 10 set, every other address bit 0, and `sd_ba` equal to 0.
- R4: The first auto-refresh (0001, address 0, bank 0) comes TRP_CYCLES after the precharge. Exactly REFRESH_COUNT refreshes are issued, each TRC_CYCLES after the previous one, with no-operation on every cycle in between.
- R5: The mode-register write (0000, bank 0) comes TRC_CYCLES after the last refresh. It carries an address equal to BURST_CODE + 8·INTERLEAVE + 16·CAS_LATENCY + 512·SINGLE_WRITE. Address bits 7, 8, 10 and 11 are 0.
- R6: `init_done` is 0 until MRS_HOLD cycles after the mode-register write, then 1 until reset.
- R7: While `init_done` is 1, the command is no-operation with address 0 and bank 0.
- R8: While `rst` is 1, the outputs hold no-operation, address 0, bank 0 and `init_done` 0. Releasing reset at any point restarts the sequence at R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Byte masks |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The block's only inputs are the clock and the synchronous reset. The assertions assume that reset is sampled on rising edges and held for at least one edge. They also assume TRP_CYCLES, TRC_CYCLES and MRS_HOLD are each at least 1. The stimulus changes reset only on falling edges and holds it for two or more edges. Both bench instances use delay parameters of 2 or more. One reset is deliberately placed in the middle of the refresh phase to exercise restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD_MODE = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_NOP       = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_PRE_GAP,
    ST_REF_GAP,
    ST_MODE_GAP,
    ST_READY
  } seq_state_e;

  localparam int PRECHARGE_ALL_BIT = 10;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W     = 16,
  parameter int RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= CNT_W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_mode_word.sv
module sdram_init_mode_word #(
  parameter int          ADDR_W      = 12,
  parameter logic [2:0]  BURST_CODE  = 3'b011,
  parameter bit          INTERLEAVE  = 1'b0,
  parameter int          CAS_LATENCY = 2,
  parameter bit          SINGLE_WRITE = 1'b0
) (
  output logic [ADDR_W-1:0] word
);
  always_comb begin
    word      = '0;
    word[2:0] = BURST_CODE;
    word[3]   = INTERLEAVE;
    word[6:4] = 3'(CAS_LATENCY);
    word[9]   = SINGLE_WRITE;
  end
endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int CNT_W         = 16,
  parameter int TRP_CYCLES    = 2,
  parameter int TRC_CYCLES    = 7,
  parameter int REFRESH_COUNT = 8,
  parameter int MRS_HOLD      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_zero,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output cmd_e              cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);
  localparam int REF_W = $clog2(REFRESH_COUNT + 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRECHARGE_ALL_BIT;

  seq_state_e        state_q, state_d;
  logic [REF_W-1:0]  ref_q;
  logic              ref_inc;
  cmd_e              cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic              done_d;

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_inc  = 1'b0;
    if (tmr_zero) begin
      case (state_q)
        ST_POWERUP: begin
          cmd_d    = CMD_PRECHARGE;
          addr_d   = PRE_ADDR;
          state_d  = ST_PRE_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TRP_CYCLES - 1);
        end
        ST_PRE_GAP: begin
          cmd_d    = CMD_REFRESH;
          ref_inc  = 1'b1;
          state_d  = ST_REF_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TRC_CYCLES - 1);
        end
        ST_REF_GAP: begin
          tmr_load = 1'b1;
          if (ref_q == REF_W'(REFRESH_COUNT)) begin
            cmd_d   = CMD_LOAD_MODE;
            addr_d  = mode_word;
            state_d = ST_MODE_GAP;
            tmr_val = CNT_W'(MRS_HOLD - 1);
          end else begin
            cmd_d   = CMD_REFRESH;
            ref_inc = 1'b1;
            tmr_val = CNT_W'(TRC_CYCLES - 1);
          end
        end
        ST_MODE_GAP: begin
          state_d = ST_READY;
          done_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_POWERUP;
      ref_q   <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ref_inc) ref_q <= ref_q + 1'b1;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int         ADDR_W        = 12,
  parameter int         BA_W          = 2,
  parameter int         DQM_W         = 2,
  parameter int         WAIT_CYCLES   = 20000,
  parameter int         TRP_CYCLES    = 2,
  parameter int         TRC_CYCLES    = 7,
  parameter int         REFRESH_COUNT = 8,
  parameter int         MRS_HOLD      = 2,
  parameter logic [2:0] BURST_CODE    = 3'b011,
  parameter bit         INTERLEAVE    = 1'b0,
  parameter int         CAS_LATENCY   = 2,
  parameter bit         SINGLE_WRITE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  import sdram_init_pkg::*;

  localparam int MAX_A   = (WAIT_CYCLES > TRC_CYCLES) ? WAIT_CYCLES : TRC_CYCLES;
  localparam int MAX_B   = (TRP_CYCLES > MRS_HOLD) ? TRP_CYCLES : MRS_HOLD;
  localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic              tmr_zero, tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] mode_word;
  cmd_e              cmd_q;

  sdram_init_timer #(.CNT_W(CNT_W), .RESET_VAL(WAIT_CYCLES - 1)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdram_init_mode_word #(
    .ADDR_W(ADDR_W), .BURST_CODE(BURST_CODE), .INTERLEAVE(INTERLEAVE),
    .CAS_LATENCY(CAS_LATENCY), .SINGLE_WRITE(SINGLE_WRITE)
  ) u_word (.word(mode_word));

  sdram_init_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TRP_CYCLES(TRP_CYCLES),
    .TRC_CYCLES(TRC_CYCLES), .REFRESH_COUNT(REFRESH_COUNT), .MRS_HOLD(MRS_HOLD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tmr_zero(tmr_zero), .mode_word(mode_word),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .cmd_q(cmd_q),
    .addr_q(sd_addr), .done_q(init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke = 1'b1;
  assign sd_dqm = '1;
  assign sd_ba  = '0;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2,
  parameter int WAIT_CYCLES   = 20000,
  parameter int TRP_CYCLES    = 2,
  parameter int TRC_CYCLES    = 7,
  parameter int REFRESH_COUNT = 8,
  parameter int MRS_HOLD      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);
  logic [3:0]  cmd;
  logic [31:0] since_rst;
  logic [15:0] gap;
  logic        last_ref, last_pre, last_mrs;
  logic [15:0] refs_seen;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      gap       <= '0;
      last_ref  <= 1'b0;
      last_pre  <= 1'b0;
      last_mrs  <= 1'b0;
      refs_seen <= '0;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      if (cmd != 4'b0111) begin
        gap      <= '0;
        last_ref <= (cmd == 4'b0001);
        last_pre <= (cmd == 4'b0010);
        last_mrs <= (cmd == 4'b0000);
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (cmd == 4'b0001) refs_seen <= refs_seen + 1'b1;
    end
  end

  a_r1_quiet_while_settling: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 32'(WAIT_CYCLES)) |-> cmd == 4'b0111);

  a_r2_cke_dqm_high: assert property (@(posedge clk) disable iff (rst)
    sd_cke && (sd_dqm == '1));

  a_r3_precharge_all_bit: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> sd_addr[10]);

  a_r4_refresh_after_pre: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'b0111 && last_pre) |-> gap >= 16'(TRP_CYCLES - 1));

  a_r4_refresh_spacing: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'b0111 && last_ref) |-> gap >= 16'(TRC_CYCLES - 1));

  a_r5_mode_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (sd_addr[8:7] == 2'b00 && sd_addr[11:10] == 2'b00 && sd_ba == '0));

  a_r5_refresh_total: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> refs_seen == 16'(REFRESH_COUNT));

  a_r6_done_after_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (last_mrs && gap >= 16'(MRS_HOLD - 1)));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r7_idle_when_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == 4'b0111 && sd_addr == '0));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .WAIT_CYCLES(WAIT_CYCLES),
  .TRP_CYCLES(TRP_CYCLES), .TRC_CYCLES(TRC_CYCLES),
  .REFRESH_COUNT(REFRESH_COUNT), .MRS_HOLD(MRS_HOLD)
) u_chk (
  .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_ba(sd_ba),
  .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
  // instance A: defaults; instance B: short delays, other mode settings
  localparam int WA = 20000, PA = 2, CA = 7, NA = 8, HA = 2;
  localparam int WB = 10, PB = 3, CB = 4, NB = 2, HB = 2;
  localparam int WORD_A = 3 + 8*0 + 16*2 + 512*0;
  localparam int WORD_B = 2 + 8*1 + 16*3 + 512*1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic [1:0]  dqm_a, ba_a;
  logic [11:0] addr_a;
  logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [1:0]  dqm_b, ba_b;
  logic [11:0] addr_b;

  sdram_init_seq uut (
    .clk(clk), .rst(rst), .sd_cke(cke_a), .sd_cs_n(cs_a), .sd_ras_n(ras_a),
    .sd_cas_n(cas_a), .sd_we_n(we_a), .sd_dqm(dqm_a), .sd_ba(ba_a),
    .sd_addr(addr_a), .init_done(done_a)
  );

  sdram_init_seq #(
    .WAIT_CYCLES(WB), .TRP_CYCLES(PB), .TRC_CYCLES(CB), .REFRESH_COUNT(NB),
    .MRS_HOLD(HB), .BURST_CODE(3'b010), .INTERLEAVE(1'b1), .CAS_LATENCY(3),
    .SINGLE_WRITE(1'b1)
  ) uut_b (
    .clk(clk), .rst(rst), .sd_cke(cke_b), .sd_cs_n(cs_b), .sd_ras_n(ras_b),
    .sd_cas_n(cas_b), .sd_we_n(we_b), .sd_dqm(dqm_b), .sd_ba(ba_b),
    .sd_addr(addr_b), .init_done(done_b)
  );

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit over = 0;

  // Behavioural model: expected command, address, done flag and requirement tag at edge t.
  task automatic model(input int tt, input int w, input int p, input int c, input int n,
                       input int h, input int word, output int cmd, output int addr,
                       output int done, output string tag);
    int pre_t, mrs_t, done_t;
    pre_t  = w;
    mrs_t  = w + p + n * c;
    done_t = mrs_t + h;
    cmd = 7; addr = 0; done = 0; tag = "R4";
    if (tt < pre_t) tag = "R1";
    else if (tt == pre_t) begin cmd = 2; addr = 1024; tag = "R3"; end
    else if (tt == mrs_t) begin cmd = 0; addr = word; tag = "R5"; end
    else if (tt > mrs_t && tt < done_t) tag = "R6";
    else if (tt >= done_t) begin done = 1; tag = "R7"; end
    else begin
      for (int k = 0; k < n; k++)
        if (tt == pre_t + p + k * c) cmd = 1;
    end
  endtask

  task automatic check(input string name, input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at t=%0d", tag, name, got, exp, t);
    end
  endtask

  // packed value: {cmd[3:0], addr[11:0], ba[1:0], done}
  function automatic int pack(input logic [3:0] c, input logic [11:0] a,
                              input logic [1:0] b, input logic d);
    return int'({c, a, b, d});
  endfunction

  task automatic compare_cycle();
    int cmd, addr, done;
    string tag;
    model(t, WA, PA, CA, NA, HA, WORD_A, cmd, addr, done, tag);
    check("uut", tag, pack({cs_a, ras_a, cas_a, we_a}, addr_a, ba_a, done_a),
          (cmd << 15) | (addr << 3) | done);
    check("uut R2 cke/dqm", "R2", {29'd0, cke_a, dqm_a}, 7);
    model(t, WB, PB, CB, NB, HB, WORD_B, cmd, addr, done, tag);
    check("uut_b", tag, pack({cs_b, ras_b, cas_b, we_b}, addr_b, ba_b, done_b),
          (cmd << 15) | (addr << 3) | done);
    check("uut_b R2 cke/dqm", "R2", {29'd0, cke_b, dqm_b}, 7);
  endtask

  task automatic check_reset();
    // R8: reset state is NOP, address 0, bank 0, done 0; R2 cke/dqm high
    check("uut reset", "R8", pack({cs_a, ras_a, cas_a, we_a}, addr_a, ba_a, done_a), 7 << 15);
    check("uut_b reset", "R8", pack({cs_b, ras_b, cas_b, we_b}, addr_b, ba_b, done_b), 7 << 15);
    check("reset cke/dqm", "R2", {26'd0, cke_a, dqm_a, cke_b, dqm_b}, 6'b111111);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      t++;
      @(negedge clk);
      compare_cycle();
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    t = 0;
    run(WA + PA + NA * CA + HA + 20);
    // R8: reset after completion, then reset in the middle of instance B's refresh phase
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    t = 0;
    run(WB + PB + 2);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    t = 0;
    run(WB + PB + NB * CB + HB + 10);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule